// File: doc/BRIEF.md
# PS/2 Keyboard Device Emulator

This block plays the keyboard end of a PS/2 link so that a host-side receiver can be exercised inside a chip or a bench. A single key is modelled by a level input that says the key is held and an 8-bit scan code. The block drives two open-drain style lines, clock and data, which idle high. Each byte is sent as an 11-bit serial frame, and the emulator clocks it out at a rate set in system clock cycles.

When the key goes down, the block sends its make code once. If the key stays down, the block waits a typematic delay and then resends the make code at a fixed repeat period. When the key is let go, the block sends a release prefix byte, waits an idle gap, and then sends the key's code again. A release that comes while a frame is on the wire takes effect only after that frame's stop bit. A busy output covers every frame and the gap inside a break sequence.

Top module: `ps2_kbd_emu`

## Requirements
- R1: After reset, and whenever busy is low, the clock line and data line are both high and busy is 0.
- R2: Every frame is 11 bits, each one valid at a falling clock edge. The order is a 0 start bit, eight data bits least significant first, a parity bit that makes the count of ones over data and parity odd, and a 1 stop bit.
- R3: The data line changes only at the middle of a clock-high half. It never changes while the clock line is low.
- R4: When key_held is high while the block is idle, the make code frame starts one cycle later.
- R5: The first repeat frame starts TYPEMATIC_CYC cycles after the end of the make frame, where a frame lasts 44*QUARTER_CYC cycles.
- R6: Later repeat frames start REPEAT_CYC cycles after the end of the previous frame, for as long as the key is held.
- R7: On release the block sends 0xF0 and then the held code. Between the end of the 0xF0 frame and the start of the code frame there are max(GAP_CYC, 4*QUARTER_CYC) idle cycles, which is at least one bit time.
- R8: A release during a frame does not cut it short. The frame completes intact and the break sequence follows it.
- R9: scan_code is captured when the key is pressed. Changes to it before the sequence returns to idle have no effect, and the break sequence repeats the captured code.
- R10: busy is high from the start of each frame through its stop bit and through the gap between the two break bytes. It is low in the waits between make and repeat frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_held | input | 1 | High while the emulated key is down |
| scan_code | input | 8 | Code of the emulated key, captured at press |
| ps2_clk_o | output | 1 | Serial clock line, idles high (drive low when 0) |
| ps2_data_o | output | 1 | Serial data line, idles high (drive low when 0) |
| busy | output | 1 | High while a frame or the break gap is in progress |

## Verification
The assertions assume that the frame engine is given a start request only while it is idle. The sequencer ensures this, because it raises a request only from states where the engine has already reported done. They also assume that key_held is a synchronous level with no further constraints. The bench drives key_held and scan_code only on the falling system clock edge. Its release times are chosen either during a hold wait or during a repeat frame, which exercises both the immediate release path and the deferred one. It also changes scan_code while the key is down to show that the captured code is the one that goes out.

// File: rtl/ps2_emu_pkg.sv
package ps2_emu_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_MAKE,
        SQ_HOLD,
        SQ_PREFIX,
        SQ_GAP,
        SQ_TAIL
    } seq_state_e;

    localparam logic [7:0] RELEASE_PREFIX = 8'hF0;
    localparam int unsigned FRAME_BITS    = 11;

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/ps2_frame_tx.sv
module ps2_frame_tx
    import ps2_emu_pkg::*;
#(
    parameter int unsigned QUARTER_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       ps2_clk_o,
    output logic       ps2_dat_o
);

    localparam int unsigned QW   = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
    localparam int unsigned LAST = FRAME_BITS - 1;

    typedef struct packed {
        logic                     sending;
        logic [QW-1:0]            qcnt;
        logic [1:0]               phase;
        logic [3:0]               bitn;
        logic [FRAME_BITS-1:0]    shreg;
        logic                     dat;
    } tx_s;

    tx_s s_d, s_q;
    logic tick;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        tick   = s_q.sending && (s_q.qcnt == QW'(QUARTER_CYC - 1));
        if (!s_q.sending) begin
            if (start_i) begin
                s_d.sending = 1'b1;
                s_d.qcnt    = '0;
                s_d.phase   = 2'd0;
                s_d.bitn    = 4'd0;
                s_d.shreg   = {1'b1, odd_par(byte_i), byte_i, 1'b0};
            end
        end else if (tick) begin
            s_d.qcnt = '0;
            unique case (s_q.phase)
                2'd0: begin
                    s_d.phase = 2'd1;
                    s_d.dat   = s_q.shreg[0];
                end
                2'd1: s_d.phase = 2'd2;
                2'd2: s_d.phase = 2'd3;
                default: begin
                    if (s_q.bitn == 4'(LAST)) begin
                        s_d.sending = 1'b0;
                        s_d.phase   = 2'd0;
                        done_o      = 1'b1;
                    end else begin
                        s_d.phase = 2'd0;
                        s_d.bitn  = s_q.bitn + 4'd1;
                        s_d.shreg = {1'b1, s_q.shreg[FRAME_BITS-1:1]};
                    end
                end
            endcase
        end else begin
            s_d.qcnt = s_q.qcnt + QW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sending: 1'b0, qcnt: '0, phase: 2'd0, bitn: 4'd0,
                     shreg: '1, dat: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = s_q.sending;
    assign ps2_clk_o = ~(s_q.sending & s_q.phase[1]);
    assign ps2_dat_o = s_q.dat;

    p_dat_stable_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_clk_o && !$past(ps2_clk_o)) |-> $stable(ps2_dat_o));

    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitn <= 4'(LAST));

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sending && s_q.bitn == 4'd0 && s_q.phase != 2'd0) |-> !ps2_dat_o);

endmodule

// File: rtl/ps2_key_seq.sv
module ps2_key_seq
    import ps2_emu_pkg::*;
#(
    parameter int unsigned TYPEMATIC_CYC = 25_000_000,
    parameter int unsigned REPEAT_CYC    = 5_000_000,
    parameter int unsigned GAP_CYC       = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_held_i,
    input  logic [7:0] code_i,
    input  logic       tx_busy_i,
    input  logic       tx_done_i,
    output logic       start_o,
    output logic [7:0] byte_o,
    output logic       gap_o
);

    localparam int unsigned MAX_AB = (TYPEMATIC_CYC > REPEAT_CYC) ? TYPEMATIC_CYC : REPEAT_CYC;
    localparam int unsigned MAXC   = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
    localparam int unsigned CW     = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [7:0]      code;
        logic            first;
        logic [CW-1:0]   cnt;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        start_o = 1'b0;
        byte_o  = s_q.code;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (key_held_i) begin
                    s_d.code  = code_i;
                    s_d.first = 1'b1;
                    s_d.st    = SQ_MAKE;
                    start_o   = 1'b1;
                    byte_o    = code_i;
                end
            end
            SQ_MAKE: begin
                if (tx_done_i) begin
                    s_d.st    = SQ_HOLD;
                    s_d.first = 1'b0;
                    s_d.cnt   = s_q.first ? CW'(TYPEMATIC_CYC - 1) : CW'(REPEAT_CYC - 1);
                end
            end
            SQ_HOLD: begin
                if (!key_held_i) begin
                    s_d.st  = SQ_PREFIX;
                    start_o = 1'b1;
                    byte_o  = RELEASE_PREFIX;
                end else if (s_q.cnt == '0) begin
                    s_d.st  = SQ_MAKE;
                    start_o = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            SQ_PREFIX: begin
                if (tx_done_i) begin
                    s_d.st  = SQ_GAP;
                    s_d.cnt = CW'(GAP_CYC - 1);
                end
            end
            SQ_GAP: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SQ_TAIL;
                    start_o = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            SQ_TAIL: begin
                if (tx_done_i) s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, code: 8'h00, first: 1'b0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign gap_o = (s_q.st == SQ_GAP);

    p_start_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !tx_busy_i);

    p_gap_line_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_GAP) |-> !tx_busy_i);

    p_code_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SQ_IDLE) |=> (s_q.code == $past(s_q.code)));

    p_release_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_MAKE && !key_held_i && !tx_done_i) |=> (s_q.st == SQ_MAKE));

endmodule

// File: rtl/ps2_kbd_emu.sv
module ps2_kbd_emu #(
    parameter int unsigned QUARTER_CYC   = 1000,
    parameter int unsigned TYPEMATIC_CYC = 25_000_000,
    parameter int unsigned REPEAT_CYC    = 5_000_000,
    parameter int unsigned GAP_CYC       = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_held,
    input  logic [7:0] scan_code,
    output logic       ps2_clk_o,
    output logic       ps2_data_o,
    output logic       busy
);

    localparam int unsigned BIT_CYC = 4 * QUARTER_CYC;
    localparam int unsigned GAP_EFF = (GAP_CYC > BIT_CYC) ? GAP_CYC : BIT_CYC;

    logic       tx_start;
    logic [7:0] tx_byte;
    logic       tx_busy;
    logic       tx_done;
    logic       seq_gap;

    ps2_key_seq #(
        .TYPEMATIC_CYC (TYPEMATIC_CYC),
        .REPEAT_CYC    (REPEAT_CYC),
        .GAP_CYC       (GAP_EFF)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_held_i (key_held),
        .code_i     (scan_code),
        .tx_busy_i  (tx_busy),
        .tx_done_i  (tx_done),
        .start_o    (tx_start),
        .byte_o     (tx_byte),
        .gap_o      (seq_gap)
    );

    ps2_frame_tx #(
        .QUARTER_CYC (QUARTER_CYC)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tx_start),
        .byte_i    (tx_byte),
        .busy_o    (tx_busy),
        .done_o    (tx_done),
        .ps2_clk_o (ps2_clk_o),
        .ps2_dat_o (ps2_data_o)
    );

    assign busy = tx_busy | seq_gap;

    p_idle_lines_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ps2_clk_o && ps2_data_o));

    p_busy_on_low_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ps2_clk_o |-> busy);

endmodule

// File: tb/ps2_kbd_emu_tb.sv
module ps2_kbd_emu_tb;

    localparam int Q      = 5;
    localparam int DLY    = 600;
    localparam int REP    = 300;
    localparam int GAP    = 30;
    localparam int FRAME  = 44 * Q;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_held = 1'b0;
    logic [7:0] scan_code = 8'h00;
    logic       ps2_clk_o, ps2_data_o, busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nfr = 0;
    int first_fall [0:63];
    int last_fall  [0:63];
    logic [7:0] exp_q [$];
    bit  in_gap = 1'b0;
    int  gap_busy_low = 0;

    always #10 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    ps2_kbd_emu #(
        .QUARTER_CYC   (Q),
        .TYPEMATIC_CYC (DLY),
        .REPEAT_CYC    (REP),
        .GAP_CYC       (GAP)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_held   (key_held),
        .scan_code  (scan_code),
        .ps2_clk_o  (ps2_clk_o),
        .ps2_data_o (ps2_data_o),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: receive frames like a host and compare against the scoreboard
    initial begin
        forever begin
            logic [10:0] fr;
            logic [7:0]  exp_b;
            @(negedge ps2_clk_o);
            if (nfr < 64) first_fall[nfr] = cyc;
            in_gap = 1'b0;
            fr[0] = ps2_data_o;
            chk(busy, "R10 busy at start bit", busy, 1);
            for (int i = 1; i < 11; i++) begin
                @(negedge ps2_clk_o);
                fr[i] = ps2_data_o;
            end
            if (nfr < 64) last_fall[nfr] = cyc;
            chk(busy, "R10 busy at stop bit", busy, 1);
            chk(fr[0] == 1'b0, "R2 start bit", fr[0], 0);
            chk(fr[10] == 1'b1, "R2 stop bit", fr[10], 1);
            chk(^fr[9:1] == 1'b1, "R2 odd parity", fr[9], ~^fr[8:1]);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected frame", fr[8:1], -1);
            end else begin
                exp_b = exp_q.pop_front();
                chk(fr[8:1] == exp_b, "R4/R7 frame byte", fr[8:1], exp_b);
            end
            if (fr[8:1] == 8'hF0) in_gap = 1'b1;
            nfr++;
        end
    end

    always @(negedge clk) if (in_gap && !busy) gap_busy_low++;

    task automatic idle_check(input string tag);
        chk(ps2_clk_o == 1'b1, {tag, " R1 clock idle"}, ps2_clk_o, 1);
        chk(ps2_data_o == 1'b1, {tag, " R1 data idle"}, ps2_data_o, 1);
        chk(busy == 1'b0, {tag, " R1 busy low"}, busy, 0);
    endtask

    // driver: press, hold, release; expected bytes go onto the scoreboard
    task automatic key_stroke(input logic [7:0] code, input int hold, input int n_make,
                              input int hold_probe);
        int base;
        int lim;
        base = nfr;
        for (int k = 0; k < n_make; k++) exp_q.push_back(code);
        exp_q.push_back(8'hF0);
        exp_q.push_back(code);
        @(negedge clk);
        scan_code = code;
        key_held  = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            if (c == 300) scan_code = ~code;            // R9: ignored change
            if (c == hold_probe) chk(busy == 1'b0, "R10 busy low in hold wait", busy, 0);
        end
        key_held = 1'b0;
        lim = 0;
        while (nfr < base + n_make + 2 && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        chk(nfr == base + n_make + 2, "R8 frame count", nfr - base, n_make + 2);
        repeat (40) @(negedge clk);
        idle_check("after stroke");
        chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        if (n_make >= 2) begin
            int d;
            d = first_fall[base + 1] - first_fall[base];
            chk(d >= FRAME + DLY && d <= FRAME + DLY + 4, "R5 first repeat spacing", d, FRAME + DLY);
        end
        if (n_make >= 3) begin
            int d;
            d = first_fall[base + 2] - first_fall[base + 1];
            chk(d >= FRAME + REP && d <= FRAME + REP + 4, "R6 repeat spacing", d, FRAME + REP);
        end
        begin
            int g;
            g = first_fall[base + n_make + 1] - last_fall[base + n_make];
            chk(g >= GAP + 4 * Q && g <= GAP + 4 * Q + 4, "R7 break gap", g, GAP + 4 * Q);
        end
        chk(gap_busy_low == 0, "R10 busy through break gap", gap_busy_low, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        idle_check("reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        idle_check("post reset");
        // R8: release at 1450 lands inside the second repeat frame
        key_stroke(8'h1C, 1450, 3, -1);
        // short tap, release during the make frame
        key_stroke(8'h00, 20, 1, -1);
        // R8: release inside first repeat frame, all-ones byte
        key_stroke(8'hFF, 1000, 2, -1);
        // release during the typematic wait, probe busy there
        key_stroke(8'h7E, 500, 1, 450);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule